// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Masked-Write Aliases

This block is the register file and pad steering for one port of eight general-purpose pins. Software reaches it over a plain 32-bit bus with select, write strobe, address and write data. The read data is combinational. Three writable registers set each pin's behaviour:

- a mode register chooses between GPIO control and an alternate on-chip function;
- a drive-enable register chooses whether the pin drives the pad;
- a level register holds the value that is driven.

A fourth register, which can only be read, returns the pad levels after a synchronizer.

Each writable register also appears at a second, masked address. The upper offset of that address is a parameter. A write to a masked address carries a per-pin enable byte in bits 15:8 and the new pin values in bits 7:0. Only the enabled pins change, so one pin can be updated without a read-modify-write. Pins that are not in GPIO mode pass the alternate function's drive and enable straight to the pad. The pad level is always forwarded to the alternate function.

Top module: `gpio_mw_port`

## Requirements
- R1: After reset, the mode, drive-enable and level registers all read 0, so every pin starts as an alternate-function pin.
- R2: A write with bus_sel=1 and bus_wr=1 to offset 0x00 (mode), 0x10 (drive enable) or 0x20 (level) loads bus_wdata[7:0] into that register on the clock edge. Bits 31:8 are ignored.
- R3: A write to MASK_OFS+0x00, MASK_OFS+0x10 or MASK_OFS+0x20 updates the matching register as follows. Bit i of bus_wdata[15:8] set: pin i takes bus_wdata[i]. Enable bit clear: pin i keeps its old value.
- R4: A masked write whose enable byte is 0x00 leaves the register unchanged, whatever the value byte holds.
- R5: For a pin whose mode bit is 1, pad_oe[i] equals its drive-enable bit and pad_out[i] equals its level bit.
- R6: For a pin whose mode bit is 0, pad_oe[i]=alt_oe[i] and pad_out[i]=alt_out[i]. alt_in always equals pad_in, with no delay.
- R7: A read of offset 0x30 returns pad_in after a synchronizer of SYNC_STAGES flops (default 2): a pad change made before clock edge n shows at the read port after edge n+1, not after edge n. Writes to 0x30 are ignored.
- R8: With bus_sel=1 and bus_wr=0, a read of a direct or masked register address returns that register in bits 7:0, with bits 31:8 at 0. Any other address, and any cycle that is not a read, returns 0.
- R9: A write to an address that maps to no writable register (for example 0x40, 0x0C or MASK_OFS+0x30) changes no register.
- R10: The masked offset MASK_OFS is a parameter with default 0x080. At that default, a read of 0x090 returns the drive-enable register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (12) | Port-relative byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| pad_in | input | 8 | Pad levels |
| pad_out | output | 8 | Value driven to the pads |
| pad_oe | output | 8 | Pad drive enables |
| alt_out | input | 8 | Alternate-function drive value |
| alt_oe | input | 8 | Alternate-function drive enable |
| alt_in | output | 8 | Pad levels forwarded to the alternate function |

## Verification
A register that holds a wrong bit shows at the pads in the cycle after the bad write, if the pin is in GPIO mode. It also shows on the next read of the register or of its alias. A masked write that disturbs a disabled pin therefore appears at once on pad_out or pad_oe, and a read-back confirms it. Synchronizer depth errors show as the input value appearing one edge early or late, so the input check samples at both edges around the expected one. A decode that aliases an unmapped address onto a register shows as a changed pad after the stray write.

// File: rtl/gpio_mw_pkg.sv
package gpio_mw_pkg;

  parameter int GP_PINS   = 8;
  parameter int GP_DATA_W = 32;

  localparam logic [31:0] OFS_MODE  = 32'h00;
  localparam logic [31:0] OFS_DRIVE = 32'h10;
  localparam logic [31:0] OFS_LEVEL = 32'h20;
  localparam logic [31:0] OFS_INPUT = 32'h30;

  typedef enum logic [2:0] {
    RS_NONE  = 3'd0,
    RS_MODE  = 3'd1,
    RS_DRIVE = 3'd2,
    RS_LEVEL = 3'd3,
    RS_INPUT = 3'd4
  } reg_sel_e;

  typedef struct packed {
    reg_sel_e sel;
    logic     masked;
  } dec_t;

  // Address decode: direct offsets, then the masked aliases of the writable registers.
  function automatic dec_t decode_addr(input logic [31:0] addr, input logic [31:0] mask_ofs);
    dec_t d;
    d.sel    = RS_NONE;
    d.masked = 1'b0;
    if (addr == OFS_MODE)                  d.sel = RS_MODE;
    else if (addr == OFS_DRIVE)            d.sel = RS_DRIVE;
    else if (addr == OFS_LEVEL)            d.sel = RS_LEVEL;
    else if (addr == OFS_INPUT)            d.sel = RS_INPUT;
    else if (addr == mask_ofs + OFS_MODE)  begin d.sel = RS_MODE;  d.masked = 1'b1; end
    else if (addr == mask_ofs + OFS_DRIVE) begin d.sel = RS_DRIVE; d.masked = 1'b1; end
    else if (addr == mask_ofs + OFS_LEVEL) begin d.sel = RS_LEVEL; d.masked = 1'b1; end
    return d;
  endfunction

  // Index of a writable register in the generate array.
  function automatic reg_sel_e field_sel(input int idx);
    case (idx)
      0:       return RS_MODE;
      1:       return RS_DRIVE;
      default: return RS_LEVEL;
    endcase
  endfunction

  // Per-pin merge: enabled pins take the new value, the rest keep the old one.
  function automatic logic [GP_PINS-1:0] merge_pins(input logic [GP_PINS-1:0] old_v,
                                                    input logic [GP_PINS-1:0] en,
                                                    input logic [GP_PINS-1:0] new_v);
    return (old_v & ~en) | (new_v & en);
  endfunction

  // Enable vector for a write: all pins for direct, the upper byte for masked.
  function automatic logic [GP_PINS-1:0] write_enables(input logic dir, input logic msk,
                                                       input logic [GP_DATA_W-1:0] wdata);
    if (dir) return '1;
    if (msk) return wdata[2*GP_PINS-1:GP_PINS];
    return '0;
  endfunction

endpackage

// File: rtl/gpio_mw_sync.sv
module gpio_mw_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];

  // R7
  sync_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stg[STAGES-1] == $past(stg[STAGES-2])));

endmodule

// File: rtl/gpio_mw_field.sv
module gpio_mw_field
  import gpio_mw_pkg::*;
#(
  parameter int PINS = GP_PINS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_dir,
  input  logic                 wr_msk,
  input  logic [GP_DATA_W-1:0] wdata,
  output logic [PINS-1:0]      q
);

  logic [PINS-1:0] upd_en;
  logic [PINS-1:0] nxt;
  logic            wr_any;

  assign upd_en = write_enables(wr_dir, wr_msk, wdata);
  assign nxt    = merge_pins(q, upd_en, wdata[PINS-1:0]);
  assign wr_any = wr_dir | wr_msk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (wr_any) q <= nxt;
  end

  // R2
  direct_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> (q == $past(wdata[PINS-1:0])));

  // R3
  masked_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_msk && !wr_dir) |=> (((q ^ $past(q)) & ~$past(wdata[2*PINS-1:PINS])) == '0));

  // R3
  masked_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_msk && !wr_dir) |=> (((q ^ $past(wdata[PINS-1:0])) & $past(wdata[2*PINS-1:PINS])) == '0));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_any |=> $stable(q));

endmodule

// File: rtl/gpio_mw_pad.sv
module gpio_mw_pad #(
  parameter int PINS = 8
) (
  input  logic [PINS-1:0] mode,
  input  logic [PINS-1:0] drive,
  input  logic [PINS-1:0] level,
  input  logic [PINS-1:0] alt_out,
  input  logic [PINS-1:0] alt_oe,
  output logic [PINS-1:0] pad_out,
  output logic [PINS-1:0] pad_oe
);

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    assign pad_out[i] = mode[i] ? level[i] : alt_out[i];
    assign pad_oe[i]  = mode[i] ? drive[i] : alt_oe[i];
  end

endmodule

// File: rtl/gpio_mw_port.sv
module gpio_mw_port
  import gpio_mw_pkg::*;
#(
  parameter int          ADDR_W      = 12,
  parameter logic [31:0] MASK_OFS    = 32'h080,
  parameter int          SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [GP_DATA_W-1:0] bus_wdata,
  output logic [GP_DATA_W-1:0] bus_rdata,
  input  logic [GP_PINS-1:0]   pad_in,
  output logic [GP_PINS-1:0]   pad_out,
  output logic [GP_PINS-1:0]   pad_oe,
  input  logic [GP_PINS-1:0]   alt_out,
  input  logic [GP_PINS-1:0]   alt_oe,
  output logic [GP_PINS-1:0]   alt_in
);

  localparam int NFIELDS = 3;
  localparam int PAD_W   = GP_DATA_W - GP_PINS;

  dec_t               dec;
  logic               bus_write;
  logic               bus_read;
  logic [NFIELDS-1:0] wr_dir;
  logic [NFIELDS-1:0] wr_msk;
  logic [GP_PINS-1:0] field_q [NFIELDS];
  logic [GP_PINS-1:0] in_sync;
  logic [GP_PINS-1:0] rd_val;

  assign dec       = decode_addr({{(32-ADDR_W){1'b0}}, bus_addr}, MASK_OFS);
  assign bus_write = bus_sel & bus_wr;
  assign bus_read  = bus_sel & ~bus_wr;

  for (genvar k = 0; k < NFIELDS; k++) begin : g_field
    assign wr_dir[k] = bus_write && (dec.sel == field_sel(k)) && !dec.masked;
    assign wr_msk[k] = bus_write && (dec.sel == field_sel(k)) &&  dec.masked;

    gpio_mw_field #(.PINS(GP_PINS)) u_field (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_dir (wr_dir[k]),
      .wr_msk (wr_msk[k]),
      .wdata  (bus_wdata),
      .q      (field_q[k])
    );
  end

  gpio_mw_sync #(.WIDTH(GP_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (in_sync)
  );

  gpio_mw_pad #(.PINS(GP_PINS)) u_pad (
    .mode    (field_q[0]),
    .drive   (field_q[1]),
    .level   (field_q[2]),
    .alt_out (alt_out),
    .alt_oe  (alt_oe),
    .pad_out (pad_out),
    .pad_oe  (pad_oe)
  );

  assign alt_in = pad_in;

  always_comb begin
    rd_val = '0;
    if (bus_read) begin
      case (dec.sel)
        RS_MODE:  rd_val = field_q[0];
        RS_DRIVE: rd_val = field_q[1];
        RS_LEVEL: rd_val = field_q[2];
        RS_INPUT: rd_val = dec.masked ? '0 : in_sync;
        default:  rd_val = '0;
      endcase
    end
  end

  assign bus_rdata = {{PAD_W{1'b0}}, rd_val};

  // R9: one write reaches at most one register
  single_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_dir, wr_msk}));

  // R5: a GPIO-mode pin whose mode and drive bits hold steady keeps its drive enable
  gpio_oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_write && field_q[0] == '1) |=> $stable(pad_oe));

endmodule

// File: tb/gpio_mw_port_tb.sv
module gpio_mw_port_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  pad_in = '0;
  logic [7:0]  pad_out, pad_oe, alt_in;
  logic [7:0]  alt_out = '0;
  logic [7:0]  alt_oe = '0;

  int checks = 0;
  int errors = 0;

  // model of register contents
  logic [7:0] m_mode = '0, m_drive = '0, m_level = '0;

  always #10 clk = ~clk;

  gpio_mw_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .alt_out(alt_out), .alt_oe(alt_oe), .alt_in(alt_in)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #5 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  function automatic logic [7:0] mrg(input logic [7:0] o, input logic [31:0] w);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = w[8+i] ? w[i] : o[i];
    return r;
  endfunction

  task automatic check_pads(input string req);
    #1;
    check({req, " pad_out"}, {24'h0, pad_out}, {24'h0, (m_mode & m_level) | (~m_mode & alt_out)});
    check({req, " pad_oe"},  {24'h0, pad_oe},  {24'h0, (m_mode & m_drive) | (~m_mode & alt_oe)});
  endtask

  task automatic t_reset();
    logic [31:0] v;
    bus_read(12'h000, v); check("R1 mode", v, 0);
    bus_read(12'h010, v); check("R1 drive", v, 0);
    bus_read(12'h020, v); check("R1 level", v, 0);
    alt_out = 8'h69; alt_oe = 8'hC3;
    check_pads("R1 R6 reset pads");
  endtask

  task automatic t_direct();
    logic [31:0] v;
    bus_write(12'h000, 32'hFFFF_FF3C); m_mode = 8'h3C;
    bus_write(12'h010, 32'h1234_56A5); m_drive = 8'hA5;
    bus_write(12'h020, 32'h0000_AB5A); m_level = 8'h5A;
    bus_read(12'h000, v); check("R2 R8 mode", v, 32'h3C);
    bus_read(12'h010, v); check("R2 drive", v, 32'hA5);
    bus_read(12'h020, v); check("R2 level", v, 32'h5A);
    bus_read(12'h090, v); check("R8 R10 alias drive", v, 32'hA5);
  endtask

  task automatic t_pads();
    alt_out = 8'h00; alt_oe = 8'hFF;
    check_pads("R5 R6 mix a");
    alt_out = 8'hFF; alt_oe = 8'h00;
    check_pads("R5 R6 mix b");
  endtask

  task automatic t_masked();
    logic [31:0] v;
    bus_write(12'h0A0, 32'h0000_0FF0); m_level = mrg(m_level, 32'h0FF0);
    bus_read(12'h020, v); check("R3 level low nibble", v, {24'h0, m_level});
    check("R3 level value", v, 32'h50);
    bus_write(12'h0A0, 32'hFFFF_C0FF); m_level = mrg(m_level, 32'hC0FF);
    bus_read(12'h0A0, v); check("R3 R8 level top pins", v, 32'hD0);
    bus_write(12'h080, 32'h0000_01FF); m_mode = mrg(m_mode, 32'h01FF);
    bus_read(12'h000, v); check("R3 single mode pin", v, 32'h3D);
    check_pads("R3 R5 pads after masked");
  endtask

  task automatic t_mask_zero();
    logic [31:0] v;
    bus_write(12'h090, 32'h0000_00FF);
    bus_read(12'h010, v); check("R4 zero enables drive", v, {24'h0, m_drive});
    bus_write(12'h080, 32'hFFFF_0000);
    bus_read(12'h000, v); check("R4 zero enables mode", v, {24'h0, m_mode});
  endtask

  task automatic t_input();
    logic [31:0] v;
    @(negedge clk);
    pad_in = 8'h96; bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 12'h030;
    #1 check("R6 alt_in", {24'h0, alt_in}, 32'h96);
    @(posedge clk); #5;
    check("R7 not after one edge", bus_rdata, 32'h00);
    @(posedge clk); #5;
    check("R7 after two edges", bus_rdata, 32'h96);
    @(negedge clk); bus_sel = 1'b0;
    bus_write(12'h030, 32'h0000_00FF);
    bus_read(12'h030, v); check("R7 write ignored", v, 32'h96);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    bus_write(12'h040, 32'h0000_FFFF);
    bus_write(12'h00C, 32'h0000_FFFF);
    bus_write(12'h0B0, 32'h0000_FFFF);
    bus_read(12'h040, v); check("R8 unmapped read", v, 0);
    bus_read(12'h0B0, v); check("R8 masked input alias", v, 0);
    bus_read(12'h000, v); check("R9 mode intact", v, {24'h0, m_mode});
    bus_read(12'h010, v); check("R9 drive intact", v, {24'h0, m_drive});
    bus_read(12'h020, v); check("R9 level intact", v, {24'h0, m_level});
    @(negedge clk); bus_addr = 12'h000; #1;
    check("R8 idle read zero", bus_rdata, 0);
    check_pads("R9 pads intact");
  endtask

  initial begin
    #4_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_direct();
    t_pads();
    t_masked();
    t_mask_zero();
    t_input();
    t_unmapped();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule